// File: doc/BRIEF.md
# Tightly-Coupled Memory Sharing and Wait-State Controller

This block sits between a processor's tightly-coupled memory port, a DMA port and one single-port synchronous SRAM. On every cycle it picks which side drives the SRAM. The choices are the live processor request, the DMA request, or a processor request it captured earlier. It also drives the processor's single wait output.

The wait output covers two stall causes. A nonsequential processor access costs one penalty cycle, and the processor also stalls while the DMA holds the memory. The DMA always wins a conflict. A processor request that arrives while the DMA is busy goes into a holding register. When the DMA stops, that request is replayed from the holding register and treated as nonsequential. The processor is expected to keep its chip select asserted while it sees wait high.

Top module: `tcm_share_ctrl`

## Requirements
- R1: After reset no request is held and the SRAM is idle. The first processor access after reset takes one wait cycle even if `cpu_seq` is 1.
- R2: A processor access with `cpu_seq` = 0 and no DMA activity sees `cpu_wait` high for exactly one cycle. It is issued to the SRAM in the next cycle, with `cpu_wait` low.
- R3: A sequential processor access (`cpu_seq` = 1) with no DMA activity, and after a completed processor access, is issued to the SRAM in the same cycle with `cpu_wait` low.
- R4: While `dma_busy` is 1, `cpu_wait` is 1 and the SRAM is driven from the DMA port (select, address, direction, data, lanes). This applies even if the processor requests in the same cycle.
- R5: A processor request seen during a DMA cycle, when none is already held, is captured: address, direction, write data and lanes. After the DMA ends, the request is issued from the capture register, not from the live port.
- R6: The first processor access after any cycle with `dma_busy` = 1 takes one wait cycle even if `cpu_seq` is 1.
- R7: Each processor access is issued to the SRAM exactly once. A replayed held request is not issued again from the live port.
- R8: `mem_we` is 1 only for write accesses (`cpu_wr`/`dma_wr` = 1 means write). For reads, `mem_be` is all zero.
- R9: Read data from the SRAM appears on `cpu_rdata` and `dma_rdata` in the cycle after the read is issued.
- R10: With `dma_busy` = 0 and `cpu_cs` = 0, `mem_cs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cs | input | 1 | Processor access request |
| cpu_seq | input | 1 | Processor marks access as sequential |
| cpu_wr | input | 1 | Processor direction, 1 = write |
| cpu_addr | input | AW (18) | Processor word address |
| cpu_wdata | input | DW (32) | Processor write data |
| cpu_be | input | DW/8 (4) | Processor byte-lane enables |
| cpu_rdata | output | DW (32) | Read data to processor |
| cpu_wait | output | 1 | Processor stall |
| dma_busy | input | 1 | DMA owns the memory this cycle |
| dma_wr | input | 1 | DMA direction, 1 = write |
| dma_addr | input | AW (18) | DMA word address |
| dma_wdata | input | DW (32) | DMA write data |
| dma_be | input | DW/8 (4) | DMA byte-lane enables |
| dma_rdata | output | DW (32) | Read data to DMA |
| mem_cs | output | 1 | SRAM select |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW (18) | SRAM address |
| mem_wdata | output | DW (32) | SRAM write data |
| mem_be | output | DW/8 (4) | SRAM byte-lane enables |
| mem_rdata | input | DW (32) | SRAM registered read data |

## Verification
The assertions check the cycle-local rules on every cycle. These are: DMA ownership and the stall it causes, at most one penalty cycle, issue when wait is low, silent lanes on reads, an idle SRAM when nobody requests, and the forced penalty right after DMA ends.

Some rules depend on history or data, and only the bench's scenarios show them. These are whether the replay uses captured rather than live values, that each access is issued exactly once, and that read data matches what earlier writes left in memory. The bench covers them with a behavioural model and a shadow memory, run with and without scrambled live inputs during holds.

// File: rtl/tcm_share_pkg.sv
// Package: shared source-select encoding and default sizes for the
// tightly-coupled memory sharing controller.
package tcm_share_pkg;

    localparam int DEF_AW = 18;
    localparam int DEF_DW = 32;

    // Which requester drives the SRAM in the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_DMA  = 2'd2,
        SRC_HOLD = 2'd3
    } src_e;

endpackage

// File: rtl/tcm_wait_gen.sv
// Module: tcm_wait_gen
// Produces the processor wait output from two causes:
//  - a one-cycle penalty for nonsequential accesses, made by feeding the
//    "penalty already served" state back through a register;
//  - DMA ownership of the memory.
// A force flag makes the first access after reset, or after any DMA cycle,
// count as nonsequential.
// Assumes: the processor keeps its request stable while wait is high.
module tcm_wait_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_busy,
    input  logic cpu_pend,   // live request or held request pending
    input  logic cpu_seq,
    output logic cpu_wait,
    output logic cpu_go      // processor access issued this cycle
);

    logic pen_served_q;
    logic force_ns_q;
    logic ns_needed;
    logic ns_wait;

    // Decide whether this cycle is a penalty cycle, an issue cycle or a stall.
    always_comb begin
        ns_needed = cpu_pend && (!cpu_seq || force_ns_q);
        ns_wait   = !dma_busy && ns_needed && !pen_served_q;
        cpu_go    = !dma_busy && cpu_pend && !ns_wait;
        cpu_wait  = dma_busy || ns_wait;
    end

    // Remember that the penalty cycle has just been spent (loopback register).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_served_q <= 1'b0;
        end else begin
            pen_served_q <= ns_wait;
        end
    end

    // Force nonsequential treatment after reset and after DMA activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_ns_q <= 1'b1;
        end else if (dma_busy) begin
            force_ns_q <= 1'b1;
        end else if (cpu_go) begin
            force_ns_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tcm_capture_reg.sv
// Module: tcm_capture_reg
// Holds a processor request that was postponed because the DMA owned the
// memory: address, direction, write data and lanes. It is filled once and
// cleared when the replay is issued.
// Assumes: cap_en and rel_en are never high in the same cycle.
module tcm_capture_reg #(
    parameter int AW = 18,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          rel_en,
    input  logic          in_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [BW-1:0] in_be,
    output logic          hold_valid,
    output logic          hold_wr,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_wdata,
    output logic [BW-1:0] hold_be
);

    // Track whether a postponed request is waiting for replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
        end else if (cap_en) begin
            hold_valid <= 1'b1;
        end else if (rel_en) begin
            hold_valid <= 1'b0;
        end
    end

    // Latch the request fields at capture time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_wr    <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
            hold_be    <= '0;
        end else if (cap_en) begin
            hold_wr    <= in_wr;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
            hold_be    <= in_be;
        end
    end

endmodule

// File: rtl/tcm_mem_mux.sv
// Module: tcm_mem_mux
// Three-way selection of the SRAM controls from the live processor port,
// the DMA port or the capture register. Lane enables are forced to zero
// for reads and when no access is issued.
// Assumes: sel is SRC_NONE in cycles with no access.
module tcm_mem_mux
    import tcm_share_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int NSRC = 3
) (
    input  src_e          sel,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic [BW-1:0] cpu_be,
    input  logic          dma_wr,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    input  logic [BW-1:0] dma_be,
    input  logic          hold_wr,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_wdata,
    input  logic [BW-1:0] hold_be,
    output logic          mem_cs,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [BW-1:0] mem_be
);

    logic [NSRC-1:0]         pick;
    logic [NSRC-1:0]         src_wr;
    logic [NSRC-1:0][AW-1:0] src_addr;
    logic [NSRC-1:0][DW-1:0] src_wdata;
    logic [NSRC-1:0][BW-1:0] src_be;

    // Pack the three sources into indexed arrays.
    always_comb begin
        pick[0] = (sel == SRC_CPU);
        pick[1] = (sel == SRC_DMA);
        pick[2] = (sel == SRC_HOLD);
        src_wr    = {hold_wr, dma_wr, cpu_wr};
        src_addr  = {hold_addr, dma_addr, cpu_addr};
        src_wdata = {hold_wdata, dma_wdata, cpu_wdata};
        src_be    = {hold_be, dma_be, cpu_be};
    end

    logic [NSRC-1:0]         g_wr;
    logic [NSRC-1:0][AW-1:0] g_addr;
    logic [NSRC-1:0][DW-1:0] g_wdata;
    logic [NSRC-1:0][BW-1:0] g_be;

    // One-hot AND-OR selection, one slice per source.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign g_wr[s]    = pick[s] & src_wr[s];
        assign g_addr[s]  = {AW{pick[s]}} & src_addr[s];
        assign g_wdata[s] = {DW{pick[s]}} & src_wdata[s];
        assign g_be[s]    = {BW{pick[s] & src_wr[s]}} & src_be[s];
    end

    // Merge the selected slice onto the SRAM controls.
    always_comb begin
        mem_cs    = |pick;
        mem_we    = |g_wr;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        for (int s = 0; s < NSRC; s++) begin
            mem_addr  = mem_addr  | g_addr[s];
            mem_wdata = mem_wdata | g_wdata[s];
            mem_be    = mem_be    | g_be[s];
        end
    end

endmodule

// File: rtl/tcm_share_ctrl.sv
// Module: tcm_share_ctrl (top)
// Shares one single-port synchronous SRAM between a processor's
// tightly-coupled port and a DMA port. DMA has priority. A processor
// request that collides with DMA is captured and replayed as a
// nonsequential access once DMA stops. The wait output covers both the
// nonsequential penalty and DMA stalls.
// Assumes: the processor holds cpu_cs high until it sees cpu_wait low. The
// SRAM returns read data one cycle after the access.
module tcm_share_ctrl
    import tcm_share_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_cs,
    input  logic          cpu_seq,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic [BW-1:0] cpu_be,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_wait,
    input  logic          dma_busy,
    input  logic          dma_wr,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    input  logic [BW-1:0] dma_be,
    output logic [DW-1:0] dma_rdata,
    output logic          mem_cs,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [BW-1:0] mem_be,
    input  logic [DW-1:0] mem_rdata
);

    logic          hold_valid;
    logic          hold_wr;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_wdata;
    logic [BW-1:0] hold_be;
    logic          cpu_pend;
    logic          cpu_go;
    logic          cap_en;
    logic          rel_en;
    src_e          sel;

    // Pending processor work is either the live port or the held copy.
    always_comb begin
        cpu_pend = cpu_cs || hold_valid;
        cap_en   = dma_busy && cpu_cs && !hold_valid;
        rel_en   = cpu_go && hold_valid;
    end

    // Pick the SRAM source for this cycle.
    always_comb begin
        if (dma_busy) begin
            sel = SRC_DMA;
        end else if (cpu_go) begin
            sel = hold_valid ? SRC_HOLD : SRC_CPU;
        end else begin
            sel = SRC_NONE;
        end
    end

    tcm_wait_gen u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_busy (dma_busy),
        .cpu_pend (cpu_pend),
        .cpu_seq  (cpu_seq),
        .cpu_wait (cpu_wait),
        .cpu_go   (cpu_go)
    );

    tcm_capture_reg #(.AW(AW), .DW(DW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .rel_en     (rel_en),
        .in_wr      (cpu_wr),
        .in_addr    (cpu_addr),
        .in_wdata   (cpu_wdata),
        .in_be      (cpu_be),
        .hold_valid (hold_valid),
        .hold_wr    (hold_wr),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .hold_be    (hold_be)
    );

    tcm_mem_mux #(.AW(AW), .DW(DW)) u_mux (
        .sel        (sel),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_be     (cpu_be),
        .dma_wr     (dma_wr),
        .dma_addr   (dma_addr),
        .dma_wdata  (dma_wdata),
        .dma_be     (dma_be),
        .hold_wr    (hold_wr),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .hold_be    (hold_be),
        .mem_cs     (mem_cs),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be)
    );

    // Registered SRAM read data goes to both requesters.
    always_comb begin
        cpu_rdata = mem_rdata;
        dma_rdata = mem_rdata;
    end

endmodule

// File: rtl/tcm_share_ctrl_chk.sv
// Module: tcm_share_ctrl_chk
// Port-level protocol checks for tcm_share_ctrl, attached with bind.
// Assumes: same processor hold rule as the controller.
module tcm_share_ctrl_chk #(
    parameter int AW = 18,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_cs,
    input logic          cpu_wait,
    input logic          dma_busy,
    input logic          dma_wr,
    input logic [AW-1:0] dma_addr,
    input logic          mem_cs,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [BW-1:0] mem_be
);

    AST_DMA_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> cpu_wait); // R4

    AST_DMA_OWNS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> (mem_cs && mem_addr == dma_addr && mem_we == dma_wr)); // R4

    AST_NS_SINGLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_busy && cpu_cs && cpu_wait) |=> (dma_busy || !cpu_wait)); // R2

    AST_NO_WAIT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_busy && cpu_cs && !cpu_wait) |-> mem_cs); // R3

    AST_READ_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && !mem_we) |-> (mem_be == '0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_busy && !cpu_cs) |-> !mem_cs); // R10

    AST_AFTER_DMA_NSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dma_busy) && !dma_busy && cpu_cs) |-> cpu_wait); // R6

endmodule

bind tcm_share_ctrl tcm_share_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_tcm_share_ctrl.sv
module tb_tcm_share_ctrl;

    localparam int AW = 18;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int MW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_cs = 1'b0, cpu_seq = 1'b0, cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [BW-1:0] cpu_be = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_wait;
    logic          dma_busy = 1'b0, dma_wr = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [DW-1:0] dma_wdata = '0;
    logic [BW-1:0] dma_be = '0;
    logic [DW-1:0] dma_rdata;
    logic          mem_cs, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [BW-1:0] mem_be;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk; // 250 MHz

    tcm_share_ctrl #(.AW(AW), .DW(DW)) dut (.*);

    // Bench SRAM: single port, registered read data.
    logic [DW-1:0] sram [MW];
    initial for (int i = 0; i < MW; i++) sram[i] = '0;
    always @(posedge clk) begin
        if (mem_cs) begin
            if (mem_we) begin
                for (int b = 0; b < BW; b++)
                    if (mem_be[b]) sram[mem_addr[5:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= sram[mem_addr[5:0]];
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // Reference model state (behavioural).
    bit            m_force;
    bit            m_pen;
    bit            m_served_since_reset;
    typedef struct { bit wr; logic [AW-1:0] addr; logic [DW-1:0] wdata; logic [BW-1:0] be; } req_t;
    req_t          m_held[$];
    logic [DW-1:0] ref_mem [MW];
    bit            rd_pend_cpu, rd_pend_dma;
    logic [DW-1:0] rd_exp;
    int            model_issues, dut_issues;

    task automatic model_reset();
        m_force = 1; m_pen = 0; m_served_since_reset = 0;
        m_held.delete();
        rd_pend_cpu = 0; rd_pend_dma = 0;
    endtask

    // Processor op under test.
    bit            op_cs, op_seq, op_wr;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_wdata;
    logic [BW-1:0] op_be;

    task automatic new_op(input int ns_pct, input int idle_pct, input int wr_pct);
        op_cs    = ($urandom % 100) >= idle_pct;
        op_seq   = ($urandom % 100) >= ns_pct;
        op_wr    = ($urandom % 100) < wr_pct;
        op_addr  = AW'($urandom % 4096);
        op_wdata = $urandom;
        op_be    = BW'($urandom);
    endtask

    task automatic run(input int n_ops, input int dma_pct, input int ns_pct,
                       input int idle_pct, input bit garble);
        int done = 0;
        new_op(ns_pct, idle_pct, 50);
        while (done < n_ops) begin
            bit pend, nswait, go, held, e_cs, e_we, e_wait;
            req_t src;
            logic [BW-1:0] e_be;
            string wtag, stag;
            // Drive inputs away from the clock edge.
            held     = (m_held.size() != 0);
            cpu_cs   = op_cs;
            cpu_seq  = op_seq;
            cpu_wr   = op_wr;
            cpu_addr = op_addr;
            cpu_wdata = op_wdata;
            cpu_be   = op_be;
            if (garble && held) begin
                cpu_seq = $urandom; cpu_wr = $urandom;
                cpu_addr = AW'($urandom); cpu_wdata = $urandom; cpu_be = BW'($urandom);
            end
            dma_busy  = ($urandom % 100) < dma_pct;
            dma_wr    = $urandom;
            dma_addr  = AW'($urandom % 4096);
            dma_wdata = $urandom;
            dma_be    = BW'($urandom);
            #1;
            // Read data from the previous cycle's read.
            if (rd_pend_cpu) chk("R9 cpu_rdata", cpu_rdata, rd_exp);
            if (rd_pend_dma) chk("R9 dma_rdata", dma_rdata, rd_exp);
            rd_pend_cpu = 0; rd_pend_dma = 0;
            // Model expectations.
            pend   = held || cpu_cs;
            nswait = !dma_busy && pend && (!cpu_seq || m_force) && !m_pen;
            go     = !dma_busy && pend && !nswait;
            e_wait = dma_busy || nswait;
            if (dma_busy)  src = '{dma_wr, dma_addr, dma_wdata, dma_be};
            else if (held) src = m_held[0];
            else           src = '{cpu_wr, cpu_addr, cpu_wdata, cpu_be};
            e_cs = dma_busy || go;
            e_we = e_cs && src.wr;
            e_be = e_we ? src.be : '0;
            if (dma_busy) wtag = "R4";
            else if (m_force && !m_served_since_reset) wtag = "R1";
            else if (m_force) wtag = "R6";
            else if (!cpu_seq) wtag = "R2";
            else wtag = "R3";
            if (dma_busy) stag = "R4";
            else if (held) stag = "R5";
            else if (!pend) stag = "R10";
            else stag = wtag;
            chk({wtag, " cpu_wait"}, DW'(cpu_wait), DW'(e_wait));
            chk({stag, " mem_cs"}, DW'(mem_cs), DW'(e_cs));
            chk({stag, " mem_we"}, DW'(mem_we), DW'(e_we));
            chk(e_we ? {stag, " mem_be"} : "R8 mem_be", DW'(mem_be), DW'(e_be));
            if (e_cs) chk({stag, " mem_addr"}, DW'(mem_addr), DW'(src.addr));
            if (e_we) chk({stag, " mem_wdata"}, mem_wdata, src.wdata);
            if (mem_cs && !dma_busy) dut_issues++;
            if (go) model_issues++;
            @(posedge clk);
            // Advance the model.
            if (e_cs) begin
                if (src.wr) begin
                    for (int b = 0; b < BW; b++)
                        if (src.be[b]) ref_mem[src.addr[5:0]][b*8 +: 8] = src.wdata[b*8 +: 8];
                end else begin
                    rd_exp = ref_mem[src.addr[5:0]];
                    rd_pend_cpu = go;
                    rd_pend_dma = dma_busy;
                end
            end
            if (dma_busy && cpu_cs && !held)
                m_held.push_back('{cpu_wr, cpu_addr, cpu_wdata, cpu_be});
            if (go && held) void'(m_held.pop_front());
            m_pen = nswait;
            if (dma_busy) m_force = 1;
            else if (go) begin m_force = 0; m_served_since_reset = 1; end
            if (!op_cs || go) begin
                done++;
                new_op(ns_pct, idle_pct, 50);
            end
            @(negedge clk);
        end
        cpu_cs = 0; dma_busy = 0;
    endtask

    initial begin
        void'($urandom(11));
        for (int i = 0; i < MW; i++) ref_mem[i] = '0;
        model_issues = 0; dut_issues = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk("R1 reset cpu_wait", DW'(cpu_wait), 0);
        chk("R1 reset mem_cs", DW'(mem_cs), 0);
        @(negedge clk);
        // Sequential stream, no DMA: first access takes the penalty (R1), rest none (R3).
        run(40, 0, 0, 0, 1'b0);
        // Nonsequential mix with idle gaps (R2, R10).
        run(200, 0, 50, 20, 1'b0);
        // DMA bursts against a stable processor (R4, R5, R6).
        run(400, 40, 30, 10, 1'b0);
        // Heavy DMA with live inputs scrambled while held: replay must use capture (R5).
        run(400, 60, 20, 5, 1'b1);
        // Long mixed run.
        run(1500, 25, 40, 15, 1'b1);
        chk("R7 issues once", DW'(dut_issues), DW'(model_issues));
        // Reset again mid-stream: force penalty reinstated, hold cleared (R1).
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk("R1 second reset mem_cs", DW'(mem_cs), 0);
        @(negedge clk);
        run(50, 0, 0, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule